// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

A watchdog peripheral on a simple 32-bit word-addressed register bus. Software must write a key sequence into a lock register before the protected register beside it will accept a write. Each protected register guards one action:
- restarting the count (kick),
- the reload value,
- turning the watchdog on or off,
- the prescale divisor.

Three of the locks take two keys. The on/off lock takes three. The low two bits of every lock register report how far its sequence has got.

Once enabled, a prescaler divides the reference clock and feeds a 16-bit down-counter. When the counter reaches zero, the block raises a one-cycle reset request. The counter then stays at zero until software reloads it, either with a kick or by enabling again. New reload and prescale values are held as staged values and only take effect at the next reload.

Top module: `wdog_keyed`

## Requirements
- R1: After reset:
  - the watchdog is disabled,
  - every lock reads 0,
  - the prescale register reads 0,
  - the reload register reads 0xFFFF,
  - the reset request is low.
- R2: The eight word addresses are:
  - 0: kick lock
  - 1: kick
  - 2: reload lock
  - 3: reload
  - 4: on/off lock
  - 5: on/off
  - 6: prescale lock
  - 7: prescale

  A lock reads its 2-bit progress in bits [1:0], with zeros above. The kick register reads 0. The reload register reads its value in bits [15:0]. The on/off register reads the enable state in bit 0. The prescale register reads its value.
- R3: The kick lock opens with 0x5555 then 0xAAAA. The reload lock opens with 0x6666 then 0xBBBB. The prescale lock opens with 0x5A5A then 0xA5A5. Each of these reads 01 after the first key and 11 after the second.
- R4: The on/off lock needs 0x7777, 0xCCCC and 0xDDDD in that order. It reads 01, then 10, then 11.
- R5: Any write to a lock register follows these rules, in this order:
  - If the word is that lock's first key, the lock goes to 01.
  - Otherwise, if the word is the next expected key, the lock advances.
  - Otherwise the lock goes to 00.
- R6: A write to a protected register takes effect only while its lock reads 11, and that write returns the lock to 00. A write while the lock is not 11 is ignored and leaves the lock unchanged.
- R7: Both of the following load the counter from the reload value, restart the prescaler and take up the staged prescale value:
  - an accepted kick write with bit 0 = 1;
  - an accepted on/off write with bit 0 = 1, which also enables the watchdog.

  An accepted on/off write with bit 0 = 0 disables the watchdog, and no reset request is raised while it is disabled.
- R8: With reload value N (N > 0) and prescale P, the reset request is first high in the N*(P+1)-th cycle after the reloading write's clock edge. It is high for exactly one cycle.
- R9: After expiry the counter holds at zero. No further request is raised until the next reload.
- R10: Writing the reload or prescale register does not alter a count in progress. The new values are used from the next reload on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Word address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdog_rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The expiry time is measured for several reload/prescale pairs (5 with divisor 3, 3 with divisor 1, 20 with divisor 1, and 4 with divisor 2). Because each product differs, a measurement tells an off-by-one in the prescaler apart from one in the counter. A pair is also restaged in the middle of a count: the first expiry must still follow the old pair and the next must follow the new one, which separates deferred from immediate loading. The lock sequences are exercised in the correct order and with a wrong key at each depth. A repeated first key and writes into partly opened locks distinguish reset-on-error from restart, and accepted writes from ignored ones.

// File: rtl/wdog_keyed.sv
module wdog_keyed #(
  parameter int DW    = 32,
  parameter int CNT_W = 16,
  parameter int PRE_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          wdog_rst_req
);

  localparam logic [15:0] KICK_K1 = 16'h5555, KICK_K2 = 16'hAAAA;
  localparam logic [15:0] RLD_K1  = 16'h6666, RLD_K2  = 16'hBBBB;
  localparam logic [15:0] ONF_K1  = 16'h7777, ONF_K2  = 16'hCCCC, ONF_K3 = 16'hDDDD;
  localparam logic [15:0] PRE_K1  = 16'h5A5A, PRE_K2  = 16'hA5A5;
  localparam logic [1:0]  OPEN    = 2'b11;

  logic [1:0]       lk_kick, lk_rld, lk_onf, lk_pre;
  logic [CNT_W-1:0] rld_reg, cnt;
  logic [PRE_W-1:0] pre_reg, pre_act, pcnt;
  logic             en, req;

  function automatic logic is_key(input logic [DW-1:0] d, input logic [15:0] k);
    return d == {{(DW-16){1'b0}}, k};
  endfunction

  function automatic logic [1:0] step2(input logic [1:0] st, input logic [DW-1:0] d,
                                       input logic [15:0] k1, input logic [15:0] k2);
    if (is_key(d, k1))                     return 2'b01;
    else if (st == 2'b01 && is_key(d, k2)) return 2'b11;
    else                                   return 2'b00;
  endfunction

  function automatic logic [1:0] step3(input logic [1:0] st, input logic [DW-1:0] d);
    if (is_key(d, ONF_K1))                     return 2'b01;
    else if (st == 2'b01 && is_key(d, ONF_K2)) return 2'b10;
    else if (st == 2'b10 && is_key(d, ONF_K3)) return 2'b11;
    else                                       return 2'b00;
  endfunction

  wire [7:0] sel = bus_wr ? (8'd1 << bus_addr) : 8'd0;

  wire acc_kick = sel[1] && lk_kick == OPEN;
  wire acc_rld  = sel[3] && lk_rld  == OPEN;
  wire acc_onf  = sel[5] && lk_onf  == OPEN;
  wire acc_pre  = sel[7] && lk_pre  == OPEN;

  wire reload = (acc_kick || acc_onf) && bus_wdata[0];
  wire tick   = pcnt == pre_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_kick <= '0;
      lk_rld  <= '0;
      lk_onf  <= '0;
      lk_pre  <= '0;
    end else begin
      if (sel[0])        lk_kick <= step2(lk_kick, bus_wdata, KICK_K1, KICK_K2);
      else if (acc_kick) lk_kick <= '0;
      if (sel[2])        lk_rld  <= step2(lk_rld, bus_wdata, RLD_K1, RLD_K2);
      else if (acc_rld)  lk_rld  <= '0;
      if (sel[4])        lk_onf  <= step3(lk_onf, bus_wdata);
      else if (acc_onf)  lk_onf  <= '0;
      if (sel[6])        lk_pre  <= step2(lk_pre, bus_wdata, PRE_K1, PRE_K2);
      else if (acc_pre)  lk_pre  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_reg <= '1;
      pre_reg <= '0;
      pre_act <= '0;
      en      <= 1'b0;
      cnt     <= '0;
      pcnt    <= '0;
      req     <= 1'b0;
    end else begin
      req <= 1'b0;
      if (acc_rld) rld_reg <= bus_wdata[CNT_W-1:0];
      if (acc_pre) pre_reg <= bus_wdata[PRE_W-1:0];
      if (acc_onf) en      <= bus_wdata[0];
      if (reload) begin
        cnt     <= rld_reg;
        pre_act <= pre_reg;
        pcnt    <= '0;
      end else if (en && cnt != '0) begin
        if (tick) begin
          pcnt <= '0;
          cnt  <= cnt - 1'b1;
          req  <= cnt == CNT_W'(1);
        end else begin
          pcnt <= pcnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      3'd0: bus_rdata[1:0]       = lk_kick;
      3'd2: bus_rdata[1:0]       = lk_rld;
      3'd3: bus_rdata[CNT_W-1:0] = rld_reg;
      3'd4: bus_rdata[1:0]       = lk_onf;
      3'd5: bus_rdata[0]         = en;
      3'd6: bus_rdata[1:0]       = lk_pre;
      3'd7: bus_rdata[PRE_W-1:0] = pre_reg;
      default: bus_rdata = '0;
    endcase
  end

  assign wdog_rst_req = req;

endmodule

module wdog_keyed_chk #(
  parameter int DW    = 32,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       bus_addr,
  input logic             bus_wr,
  input logic [DW-1:0]    bus_wdata,
  input logic [1:0]       lk_kick,
  input logic [1:0]       lk_rld,
  input logic             en,
  input logic [CNT_W-1:0] rld_reg,
  input logic             wdog_rst_req
);

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst_req |=> !wdog_rst_req); // R8

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wdog_rst_req); // R7

  AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd1 && lk_kick == 2'b11) |=> lk_kick == 2'b00); // R6

  AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd3 && lk_rld != 2'b11) |=> $stable(rld_reg)); // R6

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 3'd0 && bus_wdata != 32'h5555 && bus_wdata != 32'hAAAA)
      |=> lk_kick == 2'b00); // R5

endmodule

bind wdog_keyed wdog_keyed_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .lk_kick(lk_kick), .lk_rld(lk_rld), .en(en),
  .rld_reg(rld_reg), .wdog_rst_req(wdog_rst_req)
);

// File: tb/test_wdog_keyed.sv
module test_wdog_keyed;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        req;
  int          cyc = 0, n_chk = 0, n_fail = 0;
  bit          done = 0;

  wdog_keyed i_wdog_keyed (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_rst_req(req));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic kick();
    wr(0, 32'h5555); wr(0, 32'hAAAA); wr(1, 1);
  endtask

  task automatic set_onoff(logic v);
    wr(4, 32'h7777); wr(4, 32'hCCCC); wr(4, 32'hDDDD); wr(5, {31'b0, v});
  endtask

  task automatic set_rld(logic [15:0] v);
    wr(2, 32'h6666); wr(2, 32'hBBBB); wr(3, {16'b0, v});
  endtask

  task automatic set_pre(logic [15:0] v);
    wr(6, 32'h5A5A); wr(6, 32'hA5A5); wr(7, {16'b0, v});
  endtask

  task automatic wait_req(int start, int limit, output int el);
    el = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (req) begin el = cyc - start; return; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reset readback", d, a == 3 ? 32'hFFFF : 32'h0);
    end
    check("R1 req low", {31'b0, req}, 0);
  endtask

  task automatic t_locks();
    logic [31:0] d;
    wr(0, 32'h5555); rd(0, d); check("R3 kick lock step1", d, 1);
    wr(0, 32'hAAAA); rd(0, d); check("R3 kick lock open", d, 3);
    wr(1, 0);        rd(0, d); check("R6 kick lock clears", d, 0);
    wr(2, 32'h6666); rd(2, d); check("R3 reload lock step1", d, 1);
    wr(2, 32'hBBBB); rd(2, d); check("R3 reload lock open", d, 3);
    wr(3, 32'h0040); rd(3, d); check("R6 reload accepted", d, 32'h40);
    rd(2, d); check("R6 reload lock clears", d, 0);
    wr(6, 32'h5A5A); rd(6, d); check("R3 prescale lock step1", d, 1);
    wr(6, 32'hA5A5); rd(6, d); check("R3 prescale lock open", d, 3);
    wr(7, 32'h0002); rd(7, d); check("R2 prescale readback", d, 2);
    wr(4, 32'h7777); rd(4, d); check("R4 onoff lock step1", d, 1);
    wr(4, 32'hCCCC); rd(4, d); check("R4 onoff lock step2", d, 2);
    wr(4, 32'hDDDD); rd(4, d); check("R4 onoff lock open", d, 3);
    wr(5, 0);        rd(4, d); check("R6 onoff lock clears", d, 0);
    rd(5, d); check("R2 onoff reads off", d, 0);
  endtask

  task automatic t_wrong();
    logic [31:0] d;
    wr(0, 32'h5555); wr(0, 32'h1234); rd(0, d); check("R5 wrong key depth1", d, 0);
    wr(4, 32'h7777); wr(4, 32'hCCCC); wr(4, 32'hAAAA); rd(4, d); check("R5 wrong key depth2", d, 0);
    wr(4, 32'h7777); wr(4, 32'hDDDD); rd(4, d); check("R5 out of order key", d, 0);
    wr(2, 32'h6666); wr(2, 32'h6666); rd(2, d); check("R5 first key restarts", d, 1);
    wr(2, 32'h0); rd(2, d); check("R5 lock cleared", d, 0);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(3, 32'h0010); rd(3, d); check("R6 locked reload ignored", d, 32'h40);
    wr(2, 32'h6666); wr(3, 32'h0011); rd(3, d); check("R6 half-open ignored", d, 32'h40);
    rd(2, d); check("R6 lock unchanged by ignored write", d, 1);
    wr(2, 32'h0);
    wr(5, 1); rd(5, d); check("R6 locked onoff ignored", d, 0);
  endtask

  task automatic t_expire();
    int st, el;
    logic [31:0] d;
    set_rld(5); set_pre(2);
    wr(4, 32'h7777); wr(4, 32'hCCCC); wr(4, 32'hDDDD); wr(5, 1);
    st = cyc;
    rd(5, d); check("R7 enabled", d, 1);
    wait_req(st, 200, el); check("R8 expiry 5x3", el, 15);
    @(negedge clk); check("R8 one-cycle pulse", {31'b0, req}, 0);
    wait_req(cyc, 60, el); check("R9 no repeat after expiry", el, -1);
    kick(); st = cyc;
    wait_req(st, 200, el); check("R7 kick reloads", el, 15);
  endtask

  task automatic t_fast();
    int st, el;
    set_rld(3); set_pre(0);
    kick(); st = cyc;
    wait_req(st, 100, el); check("R8 expiry 3x1", el, 3);
  endtask

  task automatic t_deferred();
    int st, el;
    set_rld(20);
    kick(); st = cyc;
    set_rld(4); set_pre(1);
    wait_req(st, 200, el); check("R10 running count unchanged", el, 20);
    kick(); st = cyc;
    wait_req(st, 200, el); check("R10 new values at reload", el, 8);
  endtask

  task automatic t_disable();
    int el;
    logic [31:0] d;
    set_rld(12); set_pre(0);
    kick();
    set_onoff(0);
    rd(5, d); check("R7 disabled readback", d, 0);
    wait_req(cyc, 80, el); check("R7 no request while off", el, -1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_locks();
    t_wrong();
    t_ignored();
    t_expire();
    t_fast();
    t_deferred();
    t_disable();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule